// File: doc/BRIEF.md
# Environment-Controlled Memory Map Decoder

This block decodes every bus access of an 8-bit processor with a 16-bit address bus. An 8-bit environment register sets how the upper 16 KB is mapped. For each access the block asserts exactly one chip select: RAM, boot ROM, I/O page or peripheral space. It also produces the translated RAM address and a gated RAM write enable, and it drives the processor clock-speed select.

The environment register is written synchronously. Every decode is combinational from the address, the access direction, the current register value and the stack-bank value. The top 4 KB is decoded on two paths. A read there can return the ROM overlay. A write there always falls through to the RAM underneath, unless write protection blocks it.

The decoder sorts each address into one of eight windows:

- WIN_LOW covers 0x0000–0xBFFF, except page 0x01.
- WIN_STACK covers page 0x01.
- WIN_IOPG covers 0xC000–0xC0FF.
- WIN_SLOT covers 0xC100–0xC4FF.
- WIN_FIXED covers 0xC500–0xC7FF.
- WIN_EXP covers 0xC800–0xCFFF.
- WIN_HIGH covers 0xD000–0xEFFF.
- WIN_TOP covers 0xF000–0xFFFF.

The window picks the routing rule. The environment bits pick the outcome within that rule. There is no sequencing state: the only register is the environment value.

Top module: `envmap_decoder`

## Requirements
- R1: The environment register resets to 0x01 and takes the value on `env_din` at the rising clock edge at which `env_load` is high. The new value governs decoding from the following cycle.
- R2: `cpu_slow` equals environment bit 7: 1 selects the 1 MHz clock and 0 selects the 2 MHz clock.
- R3: Accesses to 0xC000–0xC0FF assert `cs_io` while environment bit 6 (I/O enable) is set. While bit 6 is clear they assert `cs_ram`.
- R4: Accesses to 0xC100–0xC4FF and 0xC800–0xCFFF assert `cs_per` while bit 6 is set. While bit 6 is clear they assert `cs_ram`.
- R5: Accesses to 0xC500–0xC7FF assert `cs_ram` whatever the value of bit 6.
- R6: While environment bit 3 (write protect) is set, a write to any RAM-mapped address at 0xC000 or above leaves `ram_we` low, and the chip select is still asserted. Writes below 0xC000 are never protected.
- R7: A read of 0xF000–0xFFFF asserts `cs_rom` while environment bit 0 (ROM enable) is set, and asserts `cs_ram` while bit 0 is clear.
- R8: A write to 0xF000–0xFFFF asserts `cs_ram` whatever the value of bit 0. It raises `ram_we` unless bit 3 is set.
- R9: When environment bit 2 is clear and `stack_bank` is below 0x20, an access to page 0x01 produces `ram_addr` = {1, 000, stack_bank[4:0], addr[7:0]}. Otherwise `ram_addr` = {0, addr}.
- R10: While `bus_req` is high exactly one of `cs_ram`, `cs_rom`, `cs_io` and `cs_per` is high. While `bus_req` is low none is high.
- R11: `ram_we` is high only on a requested write that selects RAM. Reads never raise it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| env_load | input | 1 | Loads the environment register |
| env_din | input | 8 | New environment value |
| stack_bank | input | 8 | Alternate bank value for page 0x01 |
| bus_req | input | 1 | An access is in progress this cycle |
| bus_wr | input | 1 | 1 for a write, 0 for a read |
| bus_addr | input | 16 | Processor address |
| cs_ram | output | 1 | RAM select |
| cs_rom | output | 1 | Boot ROM select |
| cs_io | output | 1 | I/O page select |
| cs_per | output | 1 | Peripheral space select |
| ram_addr | output | 17 | Translated RAM address |
| ram_we | output | 1 | Gated RAM write enable |
| cpu_slow | output | 1 | 1 for 1 MHz, 0 for 2 MHz |

## Verification
All 256 environment values are loaded in turn. Each value is paired with both edges of every window and with a read and a write at each edge. This separates the I/O-enable routing from the fixed C5–C7 window, and separates the ROM read path from the RAM write path at the top of the map. It also tells write protection inside the upper 16 KB apart from the unprotected lower map. The stack-bank value is varied alongside, so page-0x01 redirection is tried both below and above the 0x20 limit and with the stack bit in each state. An idle cycle after each load confirms that no select is asserted without a request.

// File: rtl/envmap_pkg.sv
package envmap_pkg;
    localparam int ENV_W  = 8;
    localparam int PAGE_W = 8;

    // environment bit positions
    localparam int B_SLOW = 7;
    localparam int B_IOEN = 6;
    localparam int B_VIDEN = 5;
    localparam int B_NMIEN = 4;
    localparam int B_WPROT = 3;
    localparam int B_STKSEL = 2;
    localparam int B_ROMPRI = 1;
    localparam int B_ROMEN = 0;

    typedef enum logic [2:0] {
        WIN_LOW,
        WIN_STACK,
        WIN_IOPG,
        WIN_SLOT,
        WIN_FIXED,
        WIN_EXP,
        WIN_HIGH,
        WIN_TOP
    } win_e;

    typedef struct packed {
        logic ram;
        logic rom;
        logic io;
        logic per;
    } sel_t;
endpackage

// File: rtl/envmap_envreg.sv
module envmap_envreg #(
    parameter int W = 8,
    parameter logic [W-1:0] RESET_VAL = 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] din,
    output logic [W-1:0] q
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= RESET_VAL;
        end else if (load) begin
            q <= din;
        end
    end
endmodule

// File: rtl/envmap_window.sv
module envmap_window
    import envmap_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input  logic [ADDR_W-1:0] addr,
    output win_e              win
);
    logic [PAGE_W-1:0] page;
    assign page = addr[ADDR_W-1 -: PAGE_W];

    always_comb begin
        if (page == 8'h01) begin
            win = WIN_STACK;
        end else if (page < 8'hC0) begin
            win = WIN_LOW;
        end else if (page == 8'hC0) begin
            win = WIN_IOPG;
        end else if (page <= 8'hC4) begin
            win = WIN_SLOT;
        end else if (page <= 8'hC7) begin
            win = WIN_FIXED;
        end else if (page <= 8'hCF) begin
            win = WIN_EXP;
        end else if (page <= 8'hEF) begin
            win = WIN_HIGH;
        end else begin
            win = WIN_TOP;
        end
    end
endmodule

// File: rtl/envmap_route.sv
module envmap_route
    import envmap_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int RAM_AW = ADDR_W + 1,
    parameter int BANK_LIMIT = 32
) (
    input  win_e              win,
    input  logic [ENV_W-1:0]  env,
    input  logic              bus_req,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] addr,
    input  logic [7:0]        bank,
    output sel_t              sel,
    output logic [RAM_AW-1:0] ram_addr,
    output logic              ram_we
);
    localparam int BANK_BITS = $clog2(BANK_LIMIT);
    localparam int PAD_W     = RAM_AW - 1 - BANK_BITS - PAGE_W;

    logic protect;
    logic redirect;
    sel_t raw;

    always_comb begin
        raw      = '0;
        protect  = 1'b0;
        redirect = 1'b0;
        unique case (win)
            WIN_LOW: begin
                raw.ram = 1'b1;
            end
            WIN_STACK: begin
                raw.ram  = 1'b1;
                redirect = !env[B_STKSEL] && (bank < 8'(BANK_LIMIT));
            end
            WIN_IOPG: begin
                if (env[B_IOEN]) begin
                    raw.io = 1'b1;
                end else begin
                    raw.ram = 1'b1;
                    protect = env[B_WPROT];
                end
            end
            WIN_SLOT, WIN_EXP: begin
                if (env[B_IOEN]) begin
                    raw.per = 1'b1;
                end else begin
                    raw.ram = 1'b1;
                    protect = env[B_WPROT];
                end
            end
            WIN_FIXED, WIN_HIGH: begin
                raw.ram = 1'b1;
                protect = env[B_WPROT];
            end
            WIN_TOP: begin
                if (!bus_wr && env[B_ROMEN]) begin
                    raw.rom = 1'b1;
                end else begin
                    raw.ram = 1'b1;
                    protect = env[B_WPROT];
                end
            end
        endcase
    end

    assign sel    = bus_req ? raw : '0;
    assign ram_we = bus_req && bus_wr && raw.ram && !protect;

    always_comb begin
        if (redirect) begin
            ram_addr = {1'b1, {PAD_W{1'b0}}, bank[BANK_BITS-1:0], addr[PAGE_W-1:0]};
        end else begin
            ram_addr = {{(RAM_AW-ADDR_W){1'b0}}, addr};
        end
    end
endmodule

// File: rtl/envmap_decoder.sv
module envmap_decoder
    import envmap_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int RAM_AW = ADDR_W + 1,
    parameter int BANK_LIMIT = 32,
    parameter logic [7:0] ENV_RESET = 8'h01
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              env_load,
    input  logic [7:0]        env_din,
    input  logic [7:0]        stack_bank,
    input  logic              bus_req,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    output logic              cs_ram,
    output logic              cs_rom,
    output logic              cs_io,
    output logic              cs_per,
    output logic [RAM_AW-1:0] ram_addr,
    output logic              ram_we,
    output logic              cpu_slow
);
    logic [ENV_W-1:0] env_q;
    win_e             win;
    sel_t             sel;

    envmap_envreg #(.W(ENV_W), .RESET_VAL(ENV_RESET)) u_env (
        .clk  (clk),
        .rst_n(rst_n),
        .load (env_load),
        .din  (env_din),
        .q    (env_q)
    );

    envmap_window #(.ADDR_W(ADDR_W)) u_win (
        .addr(bus_addr),
        .win (win)
    );

    envmap_route #(.ADDR_W(ADDR_W), .RAM_AW(RAM_AW), .BANK_LIMIT(BANK_LIMIT)) u_route (
        .win     (win),
        .env     (env_q),
        .bus_req (bus_req),
        .bus_wr  (bus_wr),
        .addr    (bus_addr),
        .bank    (stack_bank),
        .sel     (sel),
        .ram_addr(ram_addr),
        .ram_we  (ram_we)
    );

    assign cs_ram   = sel.ram;
    assign cs_rom   = sel.rom;
    assign cs_io    = sel.io;
    assign cs_per   = sel.per;
    assign cpu_slow = env_q[B_SLOW];
endmodule

// File: rtl/envmap_decoder_chk.sv
module envmap_decoder_chk #(
    parameter int ADDR_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              env_load,
    input logic [7:0]        env_din,
    input logic [7:0]        env_q,
    input logic              bus_req,
    input logic              bus_wr,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              cs_ram,
    input logic              cs_rom,
    input logic              cs_io,
    input logic              cs_per,
    input logic              ram_we
);
    // R1: a load is visible one cycle later
    a_r1_env_load: assert property (@(posedge clk) disable iff (!rst_n)
        env_load |=> env_q == $past(env_din));

    // R10: one select per request, none when idle
    a_r10_one_select: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req |-> $countones({cs_ram, cs_rom, cs_io, cs_per}) == 1);
    a_r10_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_req |-> $countones({cs_ram, cs_rom, cs_io, cs_per}) == 0);

    // R11: write enable only for RAM writes
    a_r11_we_on_write: assert property (@(posedge clk) disable iff (!rst_n)
        ram_we |-> (bus_req && bus_wr && cs_ram));

    // R6: protected upper-map writes never enable RAM
    a_r6_wp_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && bus_wr && env_q[3] && bus_addr >= 16'hC000) |-> !ram_we);

    // R7: ROM only on reads of the top window
    a_r7_rom_read_only: assert property (@(posedge clk) disable iff (!rst_n)
        cs_rom |-> (!bus_wr && bus_addr >= 16'hF000));

    // R3: I/O select only in the I/O page
    a_r3_io_page: assert property (@(posedge clk) disable iff (!rst_n)
        cs_io |-> (bus_addr[15:8] == 8'hC0 && env_q[6]));

    // R5: the fixed window never leaves RAM
    a_r5_fixed_ram: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && bus_addr >= 16'hC500 && bus_addr <= 16'hC7FF) |-> cs_ram);
endmodule

bind envmap_decoder envmap_decoder_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .env_load(env_load),
    .env_din (env_din),
    .env_q   (env_q),
    .bus_req (bus_req),
    .bus_wr  (bus_wr),
    .bus_addr(bus_addr),
    .cs_ram  (cs_ram),
    .cs_rom  (cs_rom),
    .cs_io   (cs_io),
    .cs_per  (cs_per),
    .ram_we  (ram_we)
);

// File: tb/envmap_decoder_tb.sv
module envmap_decoder_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        env_load = 1'b0;
    logic [7:0]  env_din = '0;
    logic [7:0]  stack_bank = '0;
    logic        bus_req = 1'b0;
    logic        bus_wr = 1'b0;
    logic [15:0] bus_addr = '0;
    logic        cs_ram, cs_rom, cs_io, cs_per, ram_we, cpu_slow;
    logic [16:0] ram_addr;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    envmap_decoder u_dut (
        .clk(clk), .rst_n(rst_n), .env_load(env_load), .env_din(env_din),
        .stack_bank(stack_bank), .bus_req(bus_req), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .cs_ram(cs_ram), .cs_rom(cs_rom), .cs_io(cs_io),
        .cs_per(cs_per), .ram_addr(ram_addr), .ram_we(ram_we), .cpu_slow(cpu_slow)
    );

    int edges[$] = '{32'h0000, 32'h0100, 32'h01FF, 32'h0200, 32'hBFFF,
                     32'hC000, 32'hC0FF, 32'hC100, 32'hC4FF, 32'hC500,
                     32'hC7FF, 32'hC800, 32'hCFFF, 32'hD000, 32'hEFFF,
                     32'hF000, 32'hFFFF};

    // behavioural reference: returns {ram,rom,io,per,we,addr[16:0]}
    function automatic logic [21:0] model(int a, bit wr, int env, int bank);
        bit ioen = env[6] != 0;
        bit wp = env[3] != 0;
        bit rom = 0, ram = 0, io = 0, per = 0, guard = 0;
        int ra = a;
        if (a >= 'hF000) begin
            if (!wr && env[0]) rom = 1; else begin ram = 1; guard = 1; end
        end else if (a >= 'hD000 || (a >= 'hC500 && a < 'hC800)) begin
            ram = 1; guard = 1;
        end else if (a >= 'hC000 && a < 'hC100) begin
            if (ioen) io = 1; else begin ram = 1; guard = 1; end
        end else if (a >= 'hC100) begin
            if (ioen) per = 1; else begin ram = 1; guard = 1; end
        end else begin
            ram = 1;
            if (a / 256 == 1 && env[2] == 0 && bank < 32)
                ra = 'h10000 + (bank * 256) + (a % 256);
        end
        return {ram, rom, io, per, (wr && ram && !(guard && wp)), 17'(ra)};
    endfunction

    function automatic string tag(int a, bit wr, int env);
        if (wr && env[3] && a >= 'hC000) return "R6";
        if (a >= 'hF000) return wr ? "R8" : "R7";
        if (a / 256 == 1) return "R9";
        if (a >= 'hC000 && a < 'hC100) return "R3";
        if ((a >= 'hC100 && a < 'hC500) || (a >= 'hC800 && a < 'hD000)) return "R4";
        if (a >= 'hC500 && a < 'hC800) return "R5";
        return "R11";
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic load_env(int e);
        @(negedge clk);
        env_load = 1'b1;
        env_din = 8'(e);
        @(negedge clk);
        env_load = 1'b0;
    endtask

    initial begin
        #(5ns * 150000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=timeout expected=done");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset value 0x01 -> ROM visible, fast clock
        @(negedge clk);
        bus_req = 1'b1; bus_wr = 1'b0; bus_addr = 16'hF000;
        #1;
        check("R1", {31'b0, cs_rom}, 32'd1);
        check("R1", {31'b0, cpu_slow}, 32'd0);
        bus_req = 1'b0;

        for (int e = 0; e < 256; e++) begin
            load_env(e);
            stack_bank = 8'((e * 7) & 8'h3F);
            #1;
            check("R2", {31'b0, cpu_slow}, {31'b0, e[7]});
            // R10: idle cycle, no select
            bus_req = 1'b0;
            check("R10", {28'b0, cs_ram, cs_rom, cs_io, cs_per}, 32'd0);
            foreach (edges[i]) begin
                for (int w = 0; w < 2; w++) begin
                    @(negedge clk);
                    bus_req = 1'b1;
                    bus_wr = w[0];
                    bus_addr = 16'(edges[i]);
                    #1;
                    check(tag(edges[i], w[0], e),
                          {10'b0, cs_ram, cs_rom, cs_io, cs_per, ram_we, ram_addr},
                          {10'b0, model(edges[i], w[0], e, int'(stack_bank))});
                    check("R10", $countones({cs_ram, cs_rom, cs_io, cs_per}), 32'd1);
                end
            end
            bus_req = 1'b0;
        end
        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule